// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of a small word-addressed shared memory that several processors reach through their own request ports. Besides ordinary reads and writes, each port can issue a load-linked, which returns a word and arms a reservation on the line holding it, and a store-conditional, which writes only while that reservation is still intact. Processors build compare-and-swap loops and spinlocks from the pair: read with load-linked, compute, then attempt the store-conditional and retry when it reports failure.

Each processor owns one reservation, a valid bit plus a line address. Lines are `LINE_BYTES` wide, so every write from another agent anywhere inside a reserved line breaks the reservation. When ports collide in one cycle, the lowest processor index takes precedence. A failed store-conditional leaves memory alone and returns zero as its result value.

Top module: `llsc_monitor`

## Requirements
- R1: After reset every `rsp_valid_o` bit is 0, every memory word reads 0 and no processor holds a reservation.
- R2: Op codes on `req_op_i` are 2'b00 read, 2'b01 write, 2'b10 load-linked and 2'b11 store-conditional. The word index is `addr[ADDR_W-1:2]`, so the two low address bits are ignored. A request accepted at a clock edge gets its response at the next edge with `rsp_valid_o` = 1. A read returns the word as it stood before that edge, and a write returns `rsp_ok_o` = 1 and data 0.
- R3: A load-linked returns the addressed word with `rsp_ok_o` = 1 and arms a reservation on line `addr[ADDR_W-1:4]`. The low four address bits do not take part in line matching.
- R4: A store-conditional to the reserved line with a valid reservation writes its data, returns `rsp_ok_o` = 1 and data 1, and consumes the reservation, so a repeated store-conditional fails.
- R5: A failed store-conditional returns `rsp_ok_o` = 0 and data 0, and leaves memory unchanged.
- R6: A store-conditional with no reservation, or with a reservation on a different line, fails.
- R7: A plain write by another processor to any word of a reserved line clears that reservation. A write to a different line does not clear it.
- R8: A successful store-conditional by one processor clears every other processor's reservation on that line.
- R9: A new load-linked replaces the issuing processor's earlier reservation.
- R10: When store-conditionals from several processors target the same line in one cycle, only the lowest-indexed one that holds a reservation succeeds.
- R11: Same-cycle writes to one word leave the lowest-indexed writer's data. A load-linked in the same cycle as another processor's write to that line returns the old word and arms no reservation.
- R12: A processor's own plain write to its reserved line does not clear its reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | NPROC | Request strobe per processor |
| req_op_i | input | 2*NPROC | Op code per processor, 2 bits each |
| req_addr_i | input | NPROC*ADDR_W | Byte address per processor |
| req_wdata_i | input | NPROC*DATA_W | Write data per processor |
| rsp_valid_o | output | NPROC | Response strobe, one cycle after the request |
| rsp_rdata_o | output | NPROC*DATA_W | Read word, or store-conditional result (1 or 0) |
| rsp_ok_o | output | NPROC | 0 only for a failed store-conditional |

## Verification
Every response is due exactly one clock edge after the edge that accepts its request. The bench therefore drives a request 1 ns after a rising edge and samples the response 1 ns after the following rising edge. Reservation effects show up one request later: a load-linked arms at its own edge, so the store-conditional issued in the next cycle already sees it. Other processors' writes clear a reservation at the edge where they land, and the bench checks this through the result of the next store-conditional. Memory effects are checked with a read in a later cycle against a word model kept in the bench.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_LL    = 2'b10,
      OP_SC    = 2'b11
   } llsc_op_e;
endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
   parameter int LINE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_i,
   input  logic [LINE_W-1:0] set_line_i,
   input  logic              kill_i,
   input  logic              drop_i,
   output logic              valid_o,
   output logic [LINE_W-1:0] line_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         line_o  <= '0;
      end else if (set_i) begin
         valid_o <= !kill_i;
         line_o  <= set_line_i;
      end else if (kill_i || drop_i) begin
         valid_o <= 1'b0;
      end
   end

   // R3, R9: a load-linked arms (or re-arms) the reservation
   p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !kill_i) |=> (valid_o && line_o == $past(set_line_i)));
   // R7, R8, R11: a foreign write to the watched line clears it
   p_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kill_i |=> !valid_o);
   // R4: an own store-conditional consumes the reservation
   p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_i && !set_i) |=> !valid_o);
   // R12: without events the reservation holds
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !kill_i && !drop_i) |=> ($stable(valid_o) && $stable(line_o)));
endmodule

// File: rtl/llsc_arb.sv
module llsc_arb #(
   parameter int NPROC  = 3,
   parameter int LINE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NPROC-1:0]  is_wr_i,
   input  logic [NPROC-1:0]  sc_hit_i,
   input  logic [LINE_W-1:0] line_i [NPROC],
   output logic [NPROC-1:0]  we_o,
   output logic [NPROC-1:0]  sc_ok_o
);
   logic [NPROC-1:0] blocked;

   always_comb begin
      blocked = '0;
      for (int p = 0; p < NPROC; p++) begin
         for (int q = 0; q < p; q++) begin
            if ((is_wr_i[q] || sc_hit_i[q]) && line_i[q] == line_i[p])
               blocked[p] = 1'b1;
         end
      end
      sc_ok_o = sc_hit_i & ~blocked;
      we_o    = is_wr_i | sc_ok_o;
   end

   generate
      for (genvar p = 0; p < NPROC; p++) begin : g_pa
         for (genvar q = p + 1; q < NPROC; q++) begin : g_pb
            // R10: two winners never share a line
            p_one_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
               (sc_ok_o[p] && sc_ok_o[q]) |-> (line_i[p] != line_i[q]));
         end
      end
   endgenerate
endmodule

// File: rtl/llsc_mem.sv
module llsc_mem #(
   parameter int NPROC    = 3,
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int WORD_LSB = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPROC-1:0]        we_i,
   input  logic [NPROC*ADDR_W-1:0] addr_i,
   input  logic [NPROC*DATA_W-1:0] wdata_i,
   output logic [NPROC*DATA_W-1:0] rdata_o
);
   localparam int IDX_W = ADDR_W - WORD_LSB;
   localparam int DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_comb begin
      for (int p = 0; p < NPROC; p++)
         rdata_o[p*DATA_W +: DATA_W] = mem[addr_i[p*ADDR_W + WORD_LSB +: IDX_W]];
   end

   // highest index first, so the lowest index lands last and wins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         for (int p = NPROC - 1; p >= 0; p--) begin
            if (we_i[p])
               mem[addr_i[p*ADDR_W + WORD_LSB +: IDX_W]] <= wdata_i[p*DATA_W +: DATA_W];
         end
      end
   end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int NPROC      = 3,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int LINE_BYTES = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPROC-1:0]        req_valid_i,
   input  logic [2*NPROC-1:0]      req_op_i,
   input  logic [NPROC*ADDR_W-1:0] req_addr_i,
   input  logic [NPROC*DATA_W-1:0] req_wdata_i,
   output logic [NPROC-1:0]        rsp_valid_o,
   output logic [NPROC*DATA_W-1:0] rsp_rdata_o,
   output logic [NPROC-1:0]        rsp_ok_o
);
   localparam int WORD_LSB = $clog2(WORD_BYTES);
   localparam int LINE_LSB = $clog2(LINE_BYTES);
   localparam int LINE_W   = ADDR_W - LINE_LSB;

   generate
      if ((1 << WORD_LSB) != WORD_BYTES || (1 << LINE_LSB) != LINE_BYTES) begin : g_bad_pow2
         initial $fatal(1, "word and line sizes must be powers of two");
      end
      if (LINE_BYTES < WORD_BYTES || LINE_LSB >= ADDR_W) begin : g_bad_line
         initial $fatal(1, "line must hold a word and fit the address");
      end
      if (NPROC < 1 || DATA_W < 1) begin : g_bad_count
         initial $fatal(1, "need at least one processor and one data bit");
      end
   endgenerate

   llsc_op_e          op     [NPROC];
   logic [LINE_W-1:0] line   [NPROC];
   logic [LINE_W-1:0] rline  [NPROC];
   logic [NPROC-1:0]  rvalid;
   logic [NPROC-1:0]  is_wr, is_ll, is_sc, sc_hit, we, sc_ok, kill;
   logic [NPROC*DATA_W-1:0] mem_rd;

   always_comb begin
      for (int p = 0; p < NPROC; p++) begin
         op[p]     = llsc_op_e'(req_op_i[2*p +: 2]);
         line[p]   = req_addr_i[p*ADDR_W + LINE_LSB +: LINE_W];
         is_wr[p]  = req_valid_i[p] && op[p] == OP_WRITE;
         is_ll[p]  = req_valid_i[p] && op[p] == OP_LL;
         is_sc[p]  = req_valid_i[p] && op[p] == OP_SC;
         sc_hit[p] = is_sc[p] && rvalid[p] && rline[p] == line[p];
      end
   end

   llsc_arb #(.NPROC(NPROC), .LINE_W(LINE_W)) i_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_wr_i  (is_wr),
      .sc_hit_i (sc_hit),
      .line_i   (line),
      .we_o     (we),
      .sc_ok_o  (sc_ok)
   );

   always_comb begin
      kill = '0;
      for (int p = 0; p < NPROC; p++) begin
         for (int q = 0; q < NPROC; q++) begin
            if (q != p && we[q] && line[q] == (is_ll[p] ? line[p] : rline[p]))
               kill[p] = 1'b1;
         end
      end
   end

   generate
      for (genvar p = 0; p < NPROC; p++) begin : g_resv
         llsc_resv #(.LINE_W(LINE_W)) i_resv (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (is_ll[p]),
            .set_line_i (line[p]),
            .kill_i     (kill[p]),
            .drop_i     (is_sc[p]),
            .valid_o    (rvalid[p]),
            .line_o     (rline[p])
         );
      end
   endgenerate

   llsc_mem #(
      .NPROC(NPROC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_LSB(WORD_LSB)
   ) i_mem (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .addr_i  (req_addr_i),
      .wdata_i (req_wdata_i),
      .rdata_o (mem_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_o <= '0;
         rsp_rdata_o <= '0;
         rsp_ok_o    <= '0;
      end else begin
         rsp_valid_o <= req_valid_i;
         for (int p = 0; p < NPROC; p++) begin
            unique case (op[p])
               OP_READ, OP_LL: rsp_rdata_o[p*DATA_W +: DATA_W] <= mem_rd[p*DATA_W +: DATA_W];
               OP_WRITE:       rsp_rdata_o[p*DATA_W +: DATA_W] <= '0;
               OP_SC:          rsp_rdata_o[p*DATA_W +: DATA_W] <= DATA_W'(sc_ok[p]);
               default:        rsp_rdata_o[p*DATA_W +: DATA_W] <= '0;
            endcase
            rsp_ok_o[p] <= (op[p] == OP_SC) ? sc_ok[p] : 1'b1;
         end
      end
   end

   generate
      for (genvar p = 0; p < NPROC; p++) begin : g_chk
         // R2: one response per request, one edge later
         p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid_i[p] |=> rsp_valid_o[p]);
         // R5: failure carries a zero result
         p_fail_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (rsp_valid_o[p] && !rsp_ok_o[p]) |-> (rsp_rdata_o[p*DATA_W +: DATA_W] == '0));
         // R6: no reservation means failure
         p_nores_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (is_sc[p] && !rvalid[p]) |=> !rsp_ok_o[p]);
      end
   endgenerate
endmodule

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
   localparam int NP = 3;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam logic [1:0] RD = 2'b00, WR = 2'b01, LL = 2'b10, SC = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    vld = '0;
   logic [2*NP-1:0]  opv = '0;
   logic [NP*AW-1:0] addr = '0;
   logic [NP*DW-1:0] wd = '0;
   logic [NP-1:0]    rsp_valid;
   logic [NP*DW-1:0] rsp_rdata;
   logic [NP-1:0]    rsp_ok;

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] mm [64];

   always #2.5 clk = ~clk;

   llsc_monitor #(.NPROC(NP), .ADDR_W(AW), .DATA_W(DW)) i_llsc_monitor (
      .clk(clk), .rst_n(rst_n), .req_valid_i(vld), .req_op_i(opv),
      .req_addr_i(addr), .req_wdata_i(wd), .rsp_valid_o(rsp_valid),
      .rsp_rdata_o(rsp_rdata), .rsp_ok_o(rsp_ok)
   );

   task automatic put(input int p, input logic [1:0] o, input logic [7:0] a, input logic [31:0] d);
      vld[p] = 1'b1;
      opv[2*p +: 2] = o;
      addr[p*AW +: AW] = a;
      wd[p*DW +: DW] = d;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
      vld = '0;
   endtask

   task automatic do1(input int p, input logic [1:0] o, input logic [7:0] a, input logic [31:0] d);
      put(p, o, a, d);
      tick();
   endtask

   function automatic logic [31:0] rdat(input int p);
      return rsp_rdata[p*DW +: DW];
   endfunction

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", r, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual hung expected finished");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 64; i++) mm[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
      rst_n = 1'b1;
      do1(1, RD, 8'h14, 0);
      chk("R1 memory zero", rdat(1), 32'h0);
      do1(0, SC, 8'h20, 32'h55);
      chk("R1 no reservation after reset", 32'(rsp_ok[0]), 32'h0);

      // R2: write every word, read back from another port with low bits set
      for (int i = 0; i < 64; i++) begin
         v = (i * 32'h01010101) ^ 32'hA5C3_0000;
         do1(i % NP, WR, 8'(i * 4), v);
         mm[i] = v;
         chk("R2 write ok", 32'(rsp_ok[i % NP]), 32'h1);
      end
      for (int i = 0; i < 64; i++) begin
         do1((i + 1) % NP, RD, 8'(i * 4 + (i % 4)), 0);
         chk("R2 read back", rdat((i + 1) % NP), mm[i]);
         chk("R2 rsp_valid", 32'(rsp_valid[(i + 1) % NP]), 32'h1);
      end

      // R3 R4 R5: LL/SC on every line from every processor
      for (int p = 0; p < NP; p++) begin
         for (int l = 0; l < 16; l++) begin
            logic [7:0] a;
            a = 8'(l * 16 + 4 * ((p + l) % 4));
            do1(p, LL, a, 0);
            chk("R3 ll data", rdat(p), mm[a >> 2]);
            v = 32'h1000_0000 + 32'(p * 256 + l);
            do1(p, SC, a | 8'h1, v);
            chk("R4 sc ok", 32'(rsp_ok[p]), 32'h1);
            chk("R4 sc result", rdat(p), 32'h1);
            mm[a >> 2] = v;
            do1(p, SC, a, v ^ 32'hFFFF);
            chk("R4 reservation consumed", 32'(rsp_ok[p]), 32'h0);
            chk("R5 fail result zero", rdat(p), 32'h0);
            do1((p + 1) % NP, RD, a, 0);
            chk("R5 memory unchanged", rdat((p + 1) % NP), mm[a >> 2]);
         end
      end

      // R6: reservation on another line
      do1(0, LL, 8'h20, 0);
      do1(0, SC, 8'h30, 32'hDEAD);
      chk("R6 wrong line fails", 32'(rsp_ok[0]), 32'h0);
      do1(1, RD, 8'h30, 0);
      chk("R6 memory unchanged", rdat(1), mm[8'h30 >> 2]);

      // R7: foreign write anywhere in the line clears; other line does not
      for (int k = 0; k < 4; k++) begin
         do1(1, LL, 8'h54, 0);
         do1(2, WR, 8'(8'h50 + 4 * k), 32'(k) + 32'h700);
         mm[(8'h50 >> 2) + k] = 32'(k) + 32'h700;
         do1(1, SC, 8'h54, 32'h1234);
         chk("R7 foreign write clears", 32'(rsp_ok[1]), 32'h0);
      end
      do1(1, LL, 8'h54, 0);
      do1(2, WR, 8'h60, 32'h777);
      mm[8'h60 >> 2] = 32'h777;
      do1(1, SC, 8'h54, 32'h4321);
      mm[8'h54 >> 2] = 32'h4321;
      chk("R7 other line keeps", 32'(rsp_ok[1]), 32'h1);

      // R8: a winning SC kills other reservations
      put(0, LL, 8'h70, 0);
      put(1, LL, 8'h78, 0);
      tick();
      do1(1, SC, 8'h78, 32'h88);
      mm[8'h78 >> 2] = 32'h88;
      chk("R8 first sc wins", 32'(rsp_ok[1]), 32'h1);
      do1(0, SC, 8'h70, 32'h99);
      chk("R8 other reservation cleared", 32'(rsp_ok[0]), 32'h0);

      // R9: new LL replaces the old one
      do1(0, LL, 8'h80, 0);
      do1(0, LL, 8'h90, 0);
      do1(0, SC, 8'h80, 32'hAA);
      chk("R9 old line dropped", 32'(rsp_ok[0]), 32'h0);
      do1(0, LL, 8'h80, 0);
      do1(0, LL, 8'h90, 0);
      do1(0, SC, 8'h90, 32'hBB);
      mm[8'h90 >> 2] = 32'hBB;
      chk("R9 new line holds", 32'(rsp_ok[0]), 32'h1);

      // R10: same-cycle SC race
      put(0, LL, 8'hA0, 0);
      put(2, LL, 8'hA4, 0);
      tick();
      put(0, SC, 8'hA0, 32'hC0);
      put(2, SC, 8'hA8, 32'hC2);
      tick();
      mm[8'hA0 >> 2] = 32'hC0;
      chk("R10 p0 wins", 32'(rsp_ok[0]), 32'h1);
      chk("R10 p2 loses", 32'(rsp_ok[2]), 32'h0);
      do1(1, RD, 8'hA8, 0);
      chk("R10 loser wrote nothing", rdat(1), mm[8'hA8 >> 2]);
      put(1, LL, 8'hA0, 0);
      put(2, LL, 8'hAC, 0);
      tick();
      put(1, SC, 8'hAC, 32'hD1);
      put(2, SC, 8'hA0, 32'hD2);
      tick();
      mm[8'hAC >> 2] = 32'hD1;
      chk("R10 p1 wins", 32'(rsp_ok[1]), 32'h1);
      chk("R10 p2 loses result", rdat(2), 32'h0);

      // R11: same-word writes and LL against a write
      put(0, WR, 8'hB0, 32'hE0);
      put(1, WR, 8'hB0, 32'hE1);
      put(2, WR, 8'hB0, 32'hE2);
      tick();
      mm[8'hB0 >> 2] = 32'hE0;
      do1(2, RD, 8'hB0, 0);
      chk("R11 lowest writer wins", rdat(2), 32'hE0);
      put(1, LL, 8'hB4, 0);
      put(0, WR, 8'hB8, 32'hF0);
      tick();
      chk("R11 ll sees old word", rdat(1), mm[8'hB4 >> 2]);
      mm[8'hB8 >> 2] = 32'hF0;
      do1(1, SC, 8'hB4, 32'hF1);
      chk("R11 ll not armed", 32'(rsp_ok[1]), 32'h0);

      // R12: own plain write keeps the reservation
      do1(0, LL, 8'hC0, 0);
      do1(0, WR, 8'hC4, 32'h12);
      mm[8'hC4 >> 2] = 32'h12;
      do1(0, SC, 8'hC0, 32'h13);
      mm[8'hC0 >> 2] = 32'h13;
      chk("R12 own write keeps", 32'(rsp_ok[0]), 32'h1);
      do1(2, RD, 8'hC4, 0);
      chk("R12 own write landed", rdat(2), 32'h12);

      summary();
      $finish;
   end
endmodule